// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block rewrites address bit 6 of tiled memory accesses so that CPU-side and graphics-side views of a buffer agree when memory is interleaved across two channels. Each access presents a physical address and a tiling type. For X-tiled and Y-tiled accesses, bit 6 is XORed with a set of higher address bits. The current swizzle mode for each tiling type picks that set. Untiled accesses pass through unchanged. The result appears one clock later.

The swizzle mode is decided from the memory channel configuration when a configuration write is strobed, and held in a small register. Two decision policies are available. The first decodes a controller control word: addressing mode, channel-XOR disable and the bit-17 select. The second compares the populated sizes of the two channels. A configuration that cannot be classified is reported as no swizzle, and a separate pin-pages flag is raised.

Top module: `swz_unit`

## Requirements
- R1: After a synchronous reset, `acc_vld_o`, `acc_addr_o`, `mode_x_o`, `mode_y_o` and `pin_pages_o` are all zero.
- R2: An access with tiling code 0 (untiled) or 3 (reserved) comes out unchanged, whatever the mode. Tiling codes are 1 = X and 2 = Y.
- R3: An X access (code 1) has bit 6 XORed with the bits of `mode_x_o`. A Y access (code 2) uses `mode_y_o` instead. The mode codes are 0 = none, 1 = bit 9, 2 = bits 9/10, 3 = bits 9/11, 4 = bits 9/10/11, 5 = bits 9/17, 6 = bits 9/10/17 and 7 = unknown.
- R4: The decode policy is selected with `cfg_policy_i` = 0. In that policy, addressing mode `cfg_word_i[1:0]` = 0 (single channel) or 1 (asymmetric dual) gives X = 0 and Y = 0.
- R5: Under the decode policy, addressing mode 2 (interleaved) with `cfg_word_i[10]` = 1 (channel XOR disabled) gives X = 2 and Y = 1.
- R6: Under the decode policy, addressing mode 2 with `cfg_word_i[10]` = 0 gives X = 4 and Y = 3 when `cfg_word_i[9]` = 0. It gives X = 6 and Y = 5 when `cfg_word_i[9]` = 1.
- R7: Under the decode policy, the mode is unknown in three cases: a control word of all ones, `cfg_lshape_i` = 1, or addressing mode 3. An unknown mode is reported as X = 0 and Y = 0 with `pin_pages_o` = 1, and no swizzle is applied. Every classified mode gives `pin_pages_o` = 0.
- R8: The compare policy is selected with `cfg_policy_i` = 1. Equal `cfg_size0_i` and `cfg_size1_i` give X = 2 and Y = 1. Unequal sizes give X = 0 and Y = 0. This policy always gives `pin_pages_o` = 0.
- R9: The configuration inputs take effect only on a clock edge with `cfg_we_i` = 1, and the new mode is visible after that edge. An access sampled on that same edge still uses the previous mode. Changing the configuration inputs without the strobe has no effect.
- R10: An access sampled on a clock edge appears on `acc_addr_o`, with `acc_vld_o` equal to its valid, after that edge. No output address bit other than bit 6 ever differs from the input address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration capture strobe |
| cfg_policy_i | input | 1 | 0 = decode control word, 1 = compare channel sizes |
| cfg_word_i | input | CW | Controller control word |
| cfg_lshape_i | input | 1 | Modified (L-shaped) memory layout active |
| cfg_size0_i | input | SZW | Populated size of channel 0 |
| cfg_size1_i | input | SZW | Populated size of channel 1 |
| acc_vld_i | input | 1 | Access valid |
| acc_addr_i | input | AW | Access physical address |
| acc_tile_i | input | 2 | Tiling type of the access |
| acc_vld_o | output | 1 | Registered access valid |
| acc_addr_o | output | AW | Registered swizzled address |
| mode_x_o | output | 3 | Reported swizzle mode for X tiling |
| mode_y_o | output | 3 | Reported swizzle mode for Y tiling |
| pin_pages_o | output | 1 | Configuration was unknown; pages must be pinned |

## Verification
The assertions assume a synchronous reset held for at least one edge. They also assume that every input carries a defined level on each edge, including the reserved tiling code and the reserved addressing mode, since both have defined behaviour. The stimulus drives every input just after a rising edge and keeps it steady until the next rising edge. It also randomises the configuration fields on cycles without the strobe, which exercises the hold behaviour without ever driving an input to an undefined level.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    AM_SINGLE = 2'd0,
    AM_ASYM   = 2'd1,
    AM_INTLV  = 2'd2,
    AM_RSVD   = 2'd3
  } addr_mode_e;

  typedef struct packed {
    swz_mode_e x;
    swz_mode_e y;
  } swz_pair_t;

  // Number of higher address bits that can feed bit 6
  localparam int unsigned NTAP = 4;

  // Mask of contributing bits, ordered {17, 11, 10, 9}
  function automatic logic [NTAP-1:0] tap_mask(swz_mode_e m);
    logic [NTAP-1:0] r;
    case (m)
      SWZ_9:       r = 4'b0001;
      SWZ_9_10:    r = 4'b0011;
      SWZ_9_11:    r = 4'b0101;
      SWZ_9_10_11: r = 4'b0111;
      SWZ_9_17:    r = 4'b1001;
      SWZ_9_10_17: r = 4'b1011;
      default:     r = 4'b0000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/swz_mode_sel.sv
module swz_mode_sel
  import swz_pkg::*;
#(
  parameter int unsigned CW       = 32,
  parameter int unsigned SZW      = 16,
  parameter int unsigned AM_LSB   = 0,
  parameter int unsigned XDIS_BIT = 10,
  parameter int unsigned X17_BIT  = 9
) (
  input  logic           policy,
  input  logic [CW-1:0]  word,
  input  logic           lshape,
  input  logic [SZW-1:0] size0,
  input  logic [SZW-1:0] size1,
  output swz_pair_t      pair
);

  addr_mode_e am;
  logic       all_ones;
  logic       xor_off;
  logic       use_b17;

  assign am       = addr_mode_e'(word[AM_LSB +: 2]);
  assign all_ones = &word;
  assign xor_off  = word[XDIS_BIT];
  assign use_b17  = word[X17_BIT];

  always_comb begin
    pair.x = SWZ_NONE;
    pair.y = SWZ_NONE;
    if (policy) begin
      if (size0 == size1) begin
        pair.x = SWZ_9_10;
        pair.y = SWZ_9;
      end
    end else if (all_ones || lshape) begin
      pair.x = SWZ_UNKNOWN;
      pair.y = SWZ_UNKNOWN;
    end else begin
      case (am)
        AM_SINGLE, AM_ASYM: begin
          pair.x = SWZ_NONE;
          pair.y = SWZ_NONE;
        end
        AM_INTLV: begin
          if (xor_off) begin
            pair.x = SWZ_9_10;
            pair.y = SWZ_9;
          end else if (!use_b17) begin
            pair.x = SWZ_9_10_11;
            pair.y = SWZ_9_11;
          end else begin
            pair.x = SWZ_9_10_17;
            pair.y = SWZ_9_17;
          end
        end
        default: begin
          pair.x = SWZ_UNKNOWN;
          pair.y = SWZ_UNKNOWN;
        end
      endcase
    end
  end

endmodule

// File: rtl/swz_cfg_reg.sv
module swz_cfg_reg
  import swz_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  swz_pair_t pair_in,
  output swz_mode_e rep_x,
  output swz_mode_e rep_y,
  output logic      pin
);

  logic unk;

  assign unk = (pair_in.x == SWZ_UNKNOWN) || (pair_in.y == SWZ_UNKNOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_x <= SWZ_NONE;
      rep_y <= SWZ_NONE;
      pin   <= 1'b0;
    end else if (we) begin
      rep_x <= unk ? SWZ_NONE : pair_in.x;
      rep_y <= unk ? SWZ_NONE : pair_in.y;
      pin   <= unk;
    end
  end

endmodule

// File: rtl/swz_xor.sv
module swz_xor
  import swz_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  tile_e         tile,
  input  swz_mode_e     mode_x,
  input  swz_mode_e     mode_y,
  output logic [AW-1:0] addr_sw
);

  localparam int unsigned TAP_POS [NTAP] = '{9, 10, 11, 17};

  swz_mode_e       sel;
  logic [NTAP-1:0] mask;
  logic [NTAP-1:0] term;
  logic            flip;

  always_comb begin
    case (tile)
      TILE_X:  sel = mode_x;
      TILE_Y:  sel = mode_y;
      default: sel = SWZ_NONE;
    endcase
  end

  assign mask = tap_mask(sel);

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign term[g] = mask[g] & addr[TAP_POS[g]];
  end

  assign flip = ^term;

  always_comb begin
    addr_sw    = addr;
    addr_sw[6] = addr[6] ^ flip;
  end

endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned CW       = 32,
  parameter int unsigned SZW      = 16,
  parameter int unsigned AM_LSB   = 0,
  parameter int unsigned XDIS_BIT = 10,
  parameter int unsigned X17_BIT  = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we_i,
  input  logic           cfg_policy_i,
  input  logic [CW-1:0]  cfg_word_i,
  input  logic           cfg_lshape_i,
  input  logic [SZW-1:0] cfg_size0_i,
  input  logic [SZW-1:0] cfg_size1_i,
  input  logic           acc_vld_i,
  input  logic [AW-1:0]  acc_addr_i,
  input  logic [1:0]     acc_tile_i,
  output logic           acc_vld_o,
  output logic [AW-1:0]  acc_addr_o,
  output logic [2:0]     mode_x_o,
  output logic [2:0]     mode_y_o,
  output logic           pin_pages_o
);

  swz_pair_t       pair_new;
  swz_mode_e       cur_x;
  swz_mode_e       cur_y;
  logic            pin_q;
  logic [AW-1:0]   addr_sw;

  swz_mode_sel #(
    .CW(CW), .SZW(SZW), .AM_LSB(AM_LSB), .XDIS_BIT(XDIS_BIT), .X17_BIT(X17_BIT)
  ) i_sel (
    .policy (cfg_policy_i),
    .word   (cfg_word_i),
    .lshape (cfg_lshape_i),
    .size0  (cfg_size0_i),
    .size1  (cfg_size1_i),
    .pair   (pair_new)
  );

  swz_cfg_reg i_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we_i),
    .pair_in (pair_new),
    .rep_x   (cur_x),
    .rep_y   (cur_y),
    .pin     (pin_q)
  );

  swz_xor #(.AW(AW)) i_xor (
    .addr    (acc_addr_i),
    .tile    (tile_e'(acc_tile_i)),
    .mode_x  (cur_x),
    .mode_y  (cur_y),
    .addr_sw (addr_sw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld_o  <= 1'b0;
      acc_addr_o <= '0;
    end else begin
      acc_vld_o  <= acc_vld_i;
      acc_addr_o <= addr_sw;
    end
  end

  assign mode_x_o    = cur_x;
  assign mode_y_o    = cur_y;
  assign pin_pages_o = pin_q;

endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we_i,
  input logic          acc_vld_i,
  input logic [AW-1:0] acc_addr_i,
  input logic [1:0]    acc_tile_i,
  input logic          acc_vld_o,
  input logic [AW-1:0] acc_addr_o,
  input logic [2:0]    mode_x_o,
  input logic [2:0]    mode_y_o,
  input logic          pin_pages_o
);

  localparam logic [AW-1:0] KEEP = ~(AW'(1) << 6);

  // R2
  a_r2_untiled_pass: assert property (@(posedge clk) disable iff (rst)
    (acc_tile_i == 2'd0 || acc_tile_i == 2'd3) |=> acc_addr_o == $past(acc_addr_i));

  // R10
  a_r10_only_bit6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((acc_addr_o ^ $past(acc_addr_i)) & KEEP) == '0);

  // R10
  a_r10_valid_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc_vld_o == $past(acc_vld_i));

  // R7
  a_r7_pin_means_none: assert property (@(posedge clk) disable iff (rst)
    pin_pages_o |-> (mode_x_o == 3'd0 && mode_y_o == 3'd0));

  // R9
  a_r9_hold_without_we: assert property (@(posedge clk) disable iff (rst)
    !cfg_we_i |=> ($stable(mode_x_o) && $stable(mode_y_o) && $stable(pin_pages_o)));

  // R3
  a_r3_x_recipe_has_10: assert property (@(posedge clk) disable iff (rst)
    (mode_x_o != 3'd1 && mode_x_o != 3'd3 && mode_x_o != 3'd5 && mode_x_o != 3'd7));

  // R3
  a_r3_pair_consistent: assert property (@(posedge clk) disable iff (rst)
    (mode_x_o == 3'd0) == (mode_y_o == 3'd0));

endmodule

bind swz_unit swz_unit_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we_i    (cfg_we_i),
  .acc_vld_i   (acc_vld_i),
  .acc_addr_i  (acc_addr_i),
  .acc_tile_i  (acc_tile_i),
  .acc_vld_o   (acc_vld_o),
  .acc_addr_o  (acc_addr_o),
  .mode_x_o    (mode_x_o),
  .mode_y_o    (mode_y_o),
  .pin_pages_o (pin_pages_o)
);

// File: tb/test_swz_unit.sv
`timescale 1ns/1ps
module test_swz_unit;

  localparam int AW = 32;
  localparam int CW = 32;
  localparam int SZW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we_i = 1'b0;
  logic           cfg_policy_i = 1'b0;
  logic [CW-1:0]  cfg_word_i = '0;
  logic           cfg_lshape_i = 1'b0;
  logic [SZW-1:0] cfg_size0_i = '0;
  logic [SZW-1:0] cfg_size1_i = '0;
  logic           acc_vld_i = 1'b0;
  logic [AW-1:0]  acc_addr_i = '0;
  logic [1:0]     acc_tile_i = 2'd0;
  logic           acc_vld_o;
  logic [AW-1:0]  acc_addr_o;
  logic [2:0]     mode_x_o;
  logic [2:0]     mode_y_o;
  logic           pin_pages_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  swz_unit i_swz_unit (.*);

  // reference state
  bit          m_vld;
  logic [AW-1:0] m_addr;
  int          m_x, m_y;
  bit          m_pin;

  function automatic bit xor_of(logic [AW-1:0] a, int code);
    bit r = 1'b0;
    if (code >= 1 && code <= 6) r = a[9];
    if (code == 2 || code == 4 || code == 6) r ^= a[10];
    if (code == 3 || code == 4) r ^= a[11];
    if (code == 5 || code == 6) r ^= a[17];
    return r;
  endfunction

  task automatic decide(output int x, output int y);
    int am = cfg_word_i[1:0];
    x = 0; y = 0;
    if (cfg_policy_i) begin
      if (cfg_size0_i == cfg_size1_i) begin x = 2; y = 1; end
    end else if (cfg_word_i == '1 || cfg_lshape_i) begin
      x = 7; y = 7;
    end else if (am == 2) begin
      if (cfg_word_i[10]) begin x = 2; y = 1; end
      else if (!cfg_word_i[9]) begin x = 4; y = 3; end
      else begin x = 6; y = 5; end
    end else if (am == 3) begin
      x = 7; y = 7;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_vld = 0; m_addr = '0; m_x = 0; m_y = 0; m_pin = 0;
    end else begin
      int code;
      int nx, ny;
      code = (acc_tile_i == 2'd1) ? m_x : (acc_tile_i == 2'd2) ? m_y : 0;
      m_vld = acc_vld_i;
      m_addr = acc_addr_i;
      m_addr[6] = acc_addr_i[6] ^ xor_of(acc_addr_i, code);
      if (cfg_we_i) begin
        decide(nx, ny);
        if (nx == 7) begin m_x = 0; m_y = 0; m_pin = 1; end
        else begin m_x = nx; m_y = ny; m_pin = 0; end
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(cur_tag, "vld", acc_vld_o, m_vld);
      chk(cur_tag, "addr", acc_addr_o, m_addr);
      chk(cur_tag, "mode_x", mode_x_o, m_x);
      chk(cur_tag, "mode_y", mode_y_o, m_y);
      chk(cur_tag, "pin", pin_pages_o, m_pin);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic traffic(int n, bit noise);
    for (int i = 0; i < n; i++) begin
      acc_vld_i  = $urandom_range(0, 3) != 0;
      acc_addr_i = $urandom;
      acc_tile_i = 2'($urandom_range(0, 3));
      cfg_we_i   = 1'b0;
      if (noise) begin
        cfg_policy_i = 1'($urandom);
        cfg_word_i   = $urandom;
        cfg_lshape_i = 1'($urandom);
        cfg_size0_i  = 16'($urandom);
      end
      step();
    end
  endtask

  task automatic load(bit pol, logic [CW-1:0] w, bit ls, int s0, int s1);
    cfg_policy_i = pol; cfg_word_i = w; cfg_lshape_i = ls;
    cfg_size0_i = 16'(s0); cfg_size1_i = 16'(s1);
    cfg_we_i = 1'b1;
    acc_vld_i = 1'b1; acc_tile_i = 2'd1; acc_addr_i = 32'h0000_0200;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic expect_modes(string tag, int x, int y, int p);
    @(negedge clk);
    chk(tag, "mode_x direct", mode_x_o, x);
    chk(tag, "mode_y direct", mode_y_o, y);
    chk(tag, "pin direct", pin_pages_o, p);
    step();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expected=finish actual=timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    @(negedge clk);
    chk("R1", "vld", acc_vld_o, 0);
    chk("R1", "addr", acc_addr_o, 0);
    chk("R1", "mode_x", mode_x_o, 0);
    chk("R1", "mode_y", mode_y_o, 0);
    chk("R1", "pin", pin_pages_o, 0);
    step();
    rst = 1'b0;
    model_on = 1'b1;
    cur_tag = "R2";
    traffic(40, 1'b0);

    cur_tag = "R5";
    load(0, 32'h0000_0402, 0, 0, 0);
    expect_modes("R5", 2, 1, 0);
    traffic(60, 1'b0);

    cur_tag = "R9";
    traffic(60, 1'b1);
    expect_modes("R9", 2, 1, 0);

    cur_tag = "R6";
    load(0, 32'h0000_0002, 0, 0, 0);
    expect_modes("R6", 4, 3, 0);
    traffic(60, 1'b0);
    load(0, 32'h0000_0202, 0, 0, 0);
    expect_modes("R6", 6, 5, 0);
    traffic(60, 1'b0);

    cur_tag = "R3";
    acc_vld_i = 1; acc_tile_i = 2'd1; acc_addr_i = 32'h0002_0000;
    step();
    @(negedge clk);
    chk("R3", "x bit17 flip", acc_addr_o, 32'h0002_0040);
    step();
    acc_tile_i = 2'd2; acc_addr_i = 32'h0000_0400;
    step();
    @(negedge clk);
    chk("R3", "y ignores bit10", acc_addr_o, 32'h0000_0400);
    step();

    cur_tag = "R2";
    acc_tile_i = 2'd3; acc_addr_i = 32'h0002_0E00;
    step();
    @(negedge clk);
    chk("R2", "reserved tile pass", acc_addr_o, 32'h0002_0E00);
    step();

    cur_tag = "R4";
    load(0, 32'h0000_0000, 0, 0, 0);
    expect_modes("R4", 0, 0, 0);
    traffic(30, 1'b0);
    load(0, 32'h0000_0001, 0, 0, 0);
    expect_modes("R4", 0, 0, 0);
    traffic(30, 1'b0);

    cur_tag = "R7";
    load(0, 32'hFFFF_FFFF, 0, 0, 0);
    expect_modes("R7", 0, 0, 1);
    traffic(30, 1'b0);
    load(0, 32'h0000_0402, 1, 0, 0);
    expect_modes("R7", 0, 0, 1);
    load(0, 32'h0000_0003, 0, 0, 0);
    expect_modes("R7", 0, 0, 1);
    traffic(30, 1'b0);

    cur_tag = "R8";
    load(1, 32'hFFFF_FFFF, 1, 512, 512);
    expect_modes("R8", 2, 1, 0);
    traffic(40, 1'b0);
    load(1, 32'h0, 0, 512, 16);
    expect_modes("R8", 0, 0, 0);
    traffic(30, 1'b0);

    cur_tag = "R10";
    load(0, 32'h0000_0202, 0, 0, 0);
    traffic(200, 1'b0);

    model_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule